// File: doc/BRIEF.md
# Write-Through Data Cache with Posted Writes

This block is an 8 KB primary data cache that sits between a processor load/store port and a plain memory bus. The cache has four ways and holds aligned 16-byte lines. It never keeps data newer than memory. Every store is placed in a four-entry posting queue and drained to memory in order. A store that hits also updates the cached word. A store that misses leaves the cache untouched.

Loads that hit return their word one cycle after acceptance and cause no memory traffic. A load that misses stalls the request port. The controller first waits until no queued store targets the same line. It then requests the whole line, writes the returning words into the victim way, and answers with the requested word. The victim is the lowest-numbered invalid way if one exists; otherwise a 3-bit tree per set picks it. A single-cycle flush pulse invalidates every line, one set per cycle.

The request port uses valid/ready. A request transfers on a cycle where `req_valid` and `req_ready` are both high, and `req_valid` with its fields must be held until that cycle. The response port has no back-pressure, so the processor must take `rsp_valid` in the cycle it appears. The memory request channel is also valid/ready, and the cache holds the request and its address steady while `mem_ready` is low. Fill data comes back on `mem_rvalid` as four consecutive beats, lowest word first, with no back-pressure.

Top module: `wtc_dcache`

## Requirements
- R1: A load that hits asserts `rsp_valid` with the cached word in the cycle after acceptance and issues no memory request.
- R2: A load that misses issues one memory read whose address has its low four bits at zero. The read is followed by four beats holding word offsets 0,1,2,3 of the line. `rsp_valid` then carries the requested word, which is selected by address bits [3:2].
- R3: A store is accepted while the posting queue has a free entry and reaches memory as a write with the same address and data. A store that hits also replaces the cached word, so a later load returns the new value without a fill.
- R4: While four stores are queued and none leaves, `req_ready` is low for a store. Queued stores to one address reach memory in issue order.
- R5: Queued stores go to memory only while no line fill is outstanding. A fill request is not issued while a queued store targets the same line, so a load never returns data older than an earlier store. A memory request held by low `mem_ready` keeps its address and direction.
- R6: A store that misses allocates no line, so a later load of that address performs a fill.
- R7: A miss fills the lowest invalid way of the set. When all four ways are valid, it uses a 3-bit tree: bit 0 set selects ways 2/3, and bit 0 clear selects ways 0/1. Bit 1 picks way 1 over way 0 when set, and bit 2 picks way 3 over way 2 when set. Each hit or fill points the tree away from the way it touched. At most one way of a set ever matches an address.
- R8: A pulse on `flush` invalidates every line and clears every tree, one set per cycle. `req_ready` stays low until the walk over all sets finishes.
- R9: After reset no line is valid, `rsp_valid` and `mem_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Single-cycle request to invalidate every line |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache accepts the request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load result valid this cycle |
| rsp_data | output | 32 | Load result |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_write | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | 32 | Word address for writes, line-aligned address for reads |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Fill beat present |
| mem_rdata | input | 32 | Fill beat data |

## Verification
Several properties are checked on every cycle by assertions. The posting queue never overflows or underflows. No set ever matches one address in two ways, and a fill never installs a line that is already resident. A fill request never goes out while a queued store covers its line, and a stalled memory request keeps its address and direction. Other behaviour shows only in the bench scenarios, which count fills and compare load data against a reference memory. These scenarios cover zero-wait hits, the stall on a full queue, store order, the no-allocate miss, the exact victim picked by the tree after a set fills, and the length of the flush walk.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int PLRU_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_MISS,
    ST_FILL_REQ,
    ST_FILL_DATA
  } ctl_st_t;

  // Tree bit 0: 1 -> victim among ways 2/3. Bit 1: way 1 over 0. Bit 2: way 3 over 2.
  function automatic logic [WAY_W-1:0] plru_victim(input logic [PLRU_W-1:0] t);
    if (!t[0]) return t[1] ? 2'd1 : 2'd0;
    else       return t[2] ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [PLRU_W-1:0] plru_touch(input logic [PLRU_W-1:0] t,
                                                   input logic [WAY_W-1:0] w);
    logic [PLRU_W-1:0] n;
    n = t;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = (w == 2'd0);
    end else begin
      n[0] = 1'b0;
      n[2] = (w == 2'd2);
    end
    return n;
  endfunction
endpackage

// File: rtl/wtc_post_fifo.sv
module wtc_post_fifo
  import wtc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int OFF_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              empty,
  output logic              full,
  input  logic [ADDR_W-OFF_W-1:0] probe_line,
  output logic              probe_hit
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_addr = addr_q[rd_q];
  assign head_data = data_q[rd_q];

  always_comb begin
    logic [PTR_W-1:0] rel;
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      rel = PTR_W'(i) - rd_q;
      if ((CNT_W'(rel) < cnt_q) && (addr_q[i][ADDR_W-1:OFF_W] == probe_line))
        probe_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_q] <= push_addr;
      data_q[wr_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= wr_q + 1'b1;
      if (pop)  rd_q <= rd_q + 1'b1;
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/wtc_store.sv
module wtc_store
  import wtc_pkg::*;
#(
  parameter int SETS   = 128,
  parameter int WORDS  = 4,
  parameter int BYTE_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-BYTE_W-1:0] look_word,
  output logic                     hit,
  output logic [WAY_W-1:0]         hit_way,
  output logic [DATA_W-1:0]        hit_word,
  output logic [WAYS-1:0]          set_valid,
  output logic [PLRU_W-1:0]        set_plru,
  input  logic                     wr_en,
  input  logic [WAY_W-1:0]         wr_way,
  input  logic [$clog2(WORDS)-1:0] wr_wsel,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     tag_en,
  input  logic                     lru_en,
  input  logic [WAY_W-1:0]         lru_way,
  input  logic                     clr_en,
  input  logic [$clog2(SETS)-1:0]  clr_set
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - BYTE_W - WSEL_W - IDX_W;

  logic [DATA_W-1:0] data_q  [SETS*WAYS*WORDS];
  logic [TAG_W-1:0]  tag_q   [SETS*WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [PLRU_W-1:0] plru_q  [SETS];

  logic [WSEL_W-1:0] wsel;
  logic [IDX_W-1:0]  set;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   hit_vec;

  assign wsel = look_word[WSEL_W-1:0];
  assign set  = look_word[WSEL_W +: IDX_W];
  assign tag  = look_word[WSEL_W+IDX_W +: TAG_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way_cmp
    assign hit_vec[w] = valid_q[set][w] && (tag_q[{set, WAY_W'(w)}] == tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  assign hit       = |hit_vec;
  assign hit_word  = data_q[{set, hit_way, wsel}];
  assign set_valid = valid_q[set];
  assign set_plru  = plru_q[set];

  always_ff @(posedge clk) begin
    if (wr_en)  data_q[{set, wr_way, wr_wsel}] <= wr_data;
    if (tag_en) tag_q[{set, wr_way}] <= tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        valid_q[i] <= '0;
        plru_q[i]  <= '0;
      end
    end else begin
      if (clr_en) begin
        valid_q[clr_set] <= '0;
        plru_q[clr_set]  <= '0;
      end
      if (tag_en) valid_q[set][wr_way] <= 1'b1;
      if (lru_en) plru_q[set] <= plru_touch(plru_q[set], lru_way);
    end
  end

  p_single_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  p_no_dup_install_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tag_en |-> !hit);
endmodule

// File: rtl/wtc_dcache.sv
module wtc_dcache
  import wtc_pkg::*;
#(
  parameter int SETS       = 128,
  parameter int WORDS      = 4,
  parameter int POST_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = BYTE_W + WSEL_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WA_W   = ADDR_W - BYTE_W;

  ctl_st_t            st_q;
  logic               flush_pend_q;
  logic [IDX_W-1:0]   fl_cnt_q;
  logic [WA_W-1:0]    miss_q;
  logic [WAY_W-1:0]   vict_q;
  logic [WSEL_W-1:0]  beat_q;
  logic [DATA_W-1:0]  keep_q;
  logic               rsp_valid_q;
  logic [DATA_W-1:0]  rsp_data_q;

  logic [WA_W-1:0]    look_word;
  logic               hit;
  logic [WAY_W-1:0]   hit_way;
  logic [DATA_W-1:0]  hit_word;
  logic [WAYS-1:0]    set_valid;
  logic [PLRU_W-1:0]  set_plru;
  logic               wr_en, tag_en, lru_en, clr_en;
  logic [WAY_W-1:0]   wr_way, lru_way, victim;
  logic [WSEL_W-1:0]  wr_wsel, miss_wsel;
  logic [DATA_W-1:0]  wr_data;

  logic               post_push, post_pop, post_empty, post_full, post_match;
  logic [ADDR_W-1:0]  post_head_addr;
  logic [DATA_W-1:0]  post_head_data;

  logic               fill_busy, acc_rd, acc_wr, last_beat;

  assign fill_busy = (st_q == ST_FILL_REQ) || (st_q == ST_FILL_DATA);
  assign req_ready = (st_q == ST_IDLE) && !flush_pend_q && (!req_write || !post_full);
  assign acc_rd    = req_valid && req_ready && !req_write;
  assign acc_wr    = req_valid && req_ready && req_write;
  assign look_word = (st_q == ST_IDLE) ? req_addr[ADDR_W-1:BYTE_W] : miss_q;
  assign miss_wsel = miss_q[WSEL_W-1:0];
  assign last_beat = (beat_q == WSEL_W'(WORDS - 1));

  always_comb begin
    victim = plru_victim(set_plru);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!set_valid[w]) victim = WAY_W'(w);
  end

  always_comb begin
    wr_en   = 1'b0;
    tag_en  = 1'b0;
    lru_en  = 1'b0;
    wr_way  = hit_way;
    lru_way = hit_way;
    wr_wsel = req_addr[BYTE_W +: WSEL_W];
    wr_data = req_wdata;
    if (acc_wr && hit) begin
      wr_en  = 1'b1;
      lru_en = 1'b1;
    end
    if (acc_rd && hit) lru_en = 1'b1;
    if (st_q == ST_FILL_DATA && mem_rvalid) begin
      wr_en   = 1'b1;
      wr_way  = vict_q;
      wr_wsel = beat_q;
      wr_data = mem_rdata;
      if (last_beat) begin
        tag_en  = 1'b1;
        lru_en  = 1'b1;
        lru_way = vict_q;
      end
    end
  end

  assign clr_en    = (st_q == ST_FLUSH);
  assign post_push = acc_wr;
  assign post_pop  = !fill_busy && !post_empty && mem_ready;

  assign mem_valid = fill_busy ? (st_q == ST_FILL_REQ) : !post_empty;
  assign mem_write = !fill_busy;
  assign mem_addr  = fill_busy ? {miss_q[WA_W-1:WSEL_W], OFF_W'(0)} : post_head_addr;
  assign mem_wdata = post_head_data;

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  wtc_store #(.SETS(SETS), .WORDS(WORDS), .BYTE_W(BYTE_W)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_word (look_word),
    .hit       (hit),
    .hit_way   (hit_way),
    .hit_word  (hit_word),
    .set_valid (set_valid),
    .set_plru  (set_plru),
    .wr_en     (wr_en),
    .wr_way    (wr_way),
    .wr_wsel   (wr_wsel),
    .wr_data   (wr_data),
    .tag_en    (tag_en),
    .lru_en    (lru_en),
    .lru_way   (lru_way),
    .clr_en    (clr_en),
    .clr_set   (fl_cnt_q)
  );

  wtc_post_fifo #(.DEPTH(POST_DEPTH), .OFF_W(OFF_W)) i_post (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (post_push),
    .push_addr  (req_addr),
    .push_data  (req_wdata),
    .pop        (post_pop),
    .head_addr  (post_head_addr),
    .head_data  (post_head_data),
    .empty      (post_empty),
    .full       (post_full),
    .probe_line (miss_q[WA_W-1:WSEL_W]),
    .probe_hit  (post_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      flush_pend_q <= 1'b0;
      fl_cnt_q     <= '0;
      miss_q       <= '0;
      vict_q       <= '0;
      beat_q       <= '0;
      keep_q       <= '0;
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (st_q == ST_IDLE && flush_pend_q) flush_pend_q <= flush;
      else if (flush)                      flush_pend_q <= 1'b1;
      case (st_q)
        ST_IDLE: begin
          if (flush_pend_q) begin
            st_q     <= ST_FLUSH;
            fl_cnt_q <= '0;
          end else if (acc_rd) begin
            if (hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= hit_word;
            end else begin
              miss_q <= req_addr[ADDR_W-1:BYTE_W];
              st_q   <= ST_MISS;
            end
          end
        end
        ST_FLUSH: begin
          fl_cnt_q <= fl_cnt_q + 1'b1;
          if (fl_cnt_q == IDX_W'(SETS - 1)) st_q <= ST_IDLE;
        end
        ST_MISS: begin
          if (!post_match && (post_empty || mem_ready)) begin
            vict_q <= victim;
            st_q   <= ST_FILL_REQ;
          end
        end
        ST_FILL_REQ: begin
          if (mem_ready) begin
            beat_q <= '0;
            st_q   <= ST_FILL_DATA;
          end
        end
        ST_FILL_DATA: begin
          if (mem_rvalid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == miss_wsel) keep_q <= mem_rdata;
            if (last_beat) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= (miss_wsel == beat_q) ? mem_rdata : keep_q;
              st_q        <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_fill_not_stale_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write) |-> !post_match);
  p_mem_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
  p_fill_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write) |-> (mem_addr[OFF_W-1:0] == '0));
  p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FLUSH) |=> !rsp_valid);
endmodule

// File: tb/test_wtc_dcache.sv
module test_wtc_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_stall = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fill_cnt = 0;
  int wr_cnt = 0;

  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] ref_m [logic [31:0]];
  logic [31:0] fill_q [$];
  logic [31:0] exp_d [$];
  int          exp_c [$];

  always #5 clk = ~clk;
  assign mem_ready = !mem_stall;

  wtc_dcache i_wtc_dcache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_model.exists(a) ? mem_model[a] : init_val(a);
  endfunction

  function automatic logic [31:0] exp_val(input logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 60000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // memory model: accepts writes and line reads at the clock edge
  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_write) begin
        mem_model[mem_addr] = mem_wdata;
        wr_cnt++;
      end else begin
        fill_q.push_back(mem_addr);
        fill_cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (fill_q.size() > 0) begin
        logic [31:0] la;
        la = fill_q.pop_front();
        repeat (2) @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_rd(la + 32'(4 * b));
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_d.size() == 0) begin
        chk(1'b0, "R2 unexpected response", rsp_data, 32'h0);
      end else begin
        logic [31:0] ed;
        int ec;
        ed = exp_d.pop_front();
        ec = exp_c.pop_front();
        chk(rsp_data == ed, "R2 load data", rsp_data, ed);
        if (ec >= 0) chk(cyc == ec, "R1 hit latency", 32'(cyc), 32'(ec));
      end
    end
  end

  task automatic cpu_op(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input bit lat, output int waits);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    waits = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    if (wr) ref_m[a] = d;
    else begin
      exp_d.push_back(exp_val(a));
      exp_c.push_back(lat ? cyc + 1 : -1);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_quiet();
    do @(negedge clk);
    while (exp_d.size() != 0 || mem_valid || mem_rvalid || fill_q.size() != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int w, f0, n0;
    logic [31:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R9 reset state
    chk(!rsp_valid, "R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk(!mem_valid, "R9 mem_valid after reset", 32'(mem_valid), 32'h0);
    chk(req_ready, "R9 req_ready after reset", 32'(req_ready), 32'h1);

    // R2 miss then R1 hit in the same line
    f0 = fill_cnt;
    cpu_op(0, 32'h0000_1008, 0, 0, w);
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R2 one fill on miss", 32'(fill_cnt - f0), 32'd1);
    cpu_op(0, 32'h0000_1004, 0, 1, w);
    cpu_op(0, 32'h0000_100C, 0, 1, w);
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R1 hits cause no fill", 32'(fill_cnt - f0), 32'd1);

    // R3 write hit updates cache and memory
    n0 = wr_cnt;
    cpu_op(1, 32'h0000_1004, 32'h1111_2222, 0, w);
    chk(w == 0, "R3 store zero wait", 32'(w), 32'd0);
    cpu_op(0, 32'h0000_1004, 0, 1, w);
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R3 read after write hit", 32'(fill_cnt - f0), 32'd1);
    chk(wr_cnt == n0 + 1, "R3 write reached memory", 32'(wr_cnt - n0), 32'd1);
    chk(mem_rd(32'h0000_1004) == 32'h1111_2222, "R3 memory value",
        mem_rd(32'h0000_1004), 32'h1111_2222);

    // R6 write miss does not allocate
    f0 = fill_cnt;
    cpu_op(1, 32'h0000_8000, 32'h0BAD_F00D, 0, w);
    wait_quiet();
    cpu_op(0, 32'h0000_8000, 0, 0, w);
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R6 load after store miss fills", 32'(fill_cnt - f0), 32'd1);

    // R4 queue full stalls stores; order kept
    n0 = wr_cnt;
    mem_stall = 1'b1;
    for (int i = 1; i <= 4; i++) begin
      cpu_op(1, 32'h0000_A040, 32'(i), 0, w);
      chk(w == 0, "R4 store accepted with free entry", 32'(w), 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_A040; req_wdata = 32'd5;
    #1;
    chk(!req_ready, "R4 stall when full", 32'(req_ready), 32'h0);
    repeat (4) @(negedge clk);
    #1;
    chk(!req_ready, "R4 stall persists", 32'(req_ready), 32'h0);
    mem_stall = 1'b0;
    while (!req_ready) begin @(negedge clk); #1; end
    ref_m[32'h0000_A040] = 32'd5;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_quiet();
    chk(wr_cnt == n0 + 5, "R4 all stores drained", 32'(wr_cnt - n0), 32'd5);
    chk(mem_rd(32'h0000_A040) == 32'd5, "R4 store order", mem_rd(32'h0000_A040), 32'd5);

    // R5 fill waits for queued store to the same line
    f0 = fill_cnt;
    mem_stall = 1'b1;
    cpu_op(1, 32'h0000_9004, 32'hDEAD_0001, 0, w);
    cpu_op(0, 32'h0000_9004, 0, 0, w);
    repeat (8) @(negedge clk);
    chk(exp_d.size() == 1, "R5 load held during stall", 32'(exp_d.size()), 32'd1);
    chk(fill_cnt == f0, "R5 no fill while blocked", 32'(fill_cnt - f0), 32'd0);
    mem_stall = 1'b0;
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R5 fill after drain", 32'(fill_cnt - f0), 32'd1);

    // R7 replacement in set 2
    base = 32'h0004_0020;
    f0 = fill_cnt;
    for (int k = 0; k < 4; k++) cpu_op(0, base + 32'(k * 32'h800), 0, 0, w);
    wait_quiet();
    chk(fill_cnt == f0 + 4, "R7 four invalid ways filled", 32'(fill_cnt - f0), 32'd4);
    cpu_op(0, base, 0, 1, w);
    cpu_op(0, base + 32'h2000, 0, 0, w);
    wait_quiet();
    chk(fill_cnt == f0 + 5, "R7 fifth line fills", 32'(fill_cnt - f0), 32'd5);
    cpu_op(0, base, 0, 1, w);
    cpu_op(0, base + 32'h800, 0, 1, w);
    cpu_op(0, base + 32'h1800, 0, 1, w);
    wait_quiet();
    chk(fill_cnt == f0 + 5, "R7 tree kept lines 0,1,3", 32'(fill_cnt - f0), 32'd5);
    cpu_op(0, base + 32'h1000, 0, 0, w);
    wait_quiet();
    chk(fill_cnt == f0 + 6, "R7 tree evicted line 2", 32'(fill_cnt - f0), 32'd6);

    // R8 flush
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk(!req_ready, "R8 ready low during flush", 32'(req_ready), 32'h0);
    f0 = fill_cnt;
    cpu_op(0, base, 0, 0, w);
    chk(w >= 100, "R8 flush walks all sets", 32'(w), 32'd100);
    wait_quiet();
    chk(fill_cnt == f0 + 1, "R8 line invalid after flush", 32'(fill_cnt - f0), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule